// File: doc/BRIEF.md
# Flyback Converter Power-Up and Protection Sequencer

This block is the supervisory state machine of a primary-side regulated flyback controller. It turns comparator flags about the supply rail, the thermal shutdown input and the protection detectors into a small set of control outputs. These outputs are the core bias enable, the command that turns off the external start-up device, a permit for the gate driver, a request to the cable-compensation calibrator, and a pulse-width ceiling that the PWM core honours during soft-start.

Once the rail passes the start threshold, the block enables the core and cuts off the start-up device. It then walks a fixed path: a thermal check, one calibration pass with the gate held off, and a soft-start ramp of the width ceiling, before it reaches normal running. When a fault trips, the gate stops while the core stays biased, so the rail drains down to the under-voltage lockout (UVLO) level and the block retries from the beginning. A static mode input selects a latching variant instead. In that variant, over-voltage or thermal faults park the block until the rail falls to a separate release level below UVLO.

Top module: `psu_boot_seq`

## Requirements
- R1: While reset is asserted and right after it, `seq_state` is 0 and `core_en`, `startup_off`, `gate_permit`, `cal_req` and `pw_ceiling` are all 0.
- R2: In the off state, the block leaves for the thermal check when the start flag is high and the UVLO flag is low. `core_en` and `startup_off` are high in every state except off and locked.
- R3: The sequence after enabling is always thermal check, then calibration, then soft-start. If `therm_ok` is low during the thermal check, the block goes straight to the fault path instead of calibration.
- R4: `cal_req` is high only in the calibration state, and `gate_permit` is low there. Calibration is left only when `cal_done` is seen, and it occurs once per start-up.
- R5: On entry to soft-start, `pw_ceiling` is 16 (1/16 of the 8-bit range). It rises by 16 after every 16 `sw_tick` pulses and saturates at 255. The state then moves to run, where the ceiling stays at 255.
- R6: `gate_permit` is high only in the soft-start and run states.
- R7: A UVLO flag in any state other than locked sends the block to off on the next update. This takes priority over every other input that arrives in the same cycle.
- R8: A fault that does not latch, raised in soft-start or run, moves the block to the drain state. There `core_en` and `startup_off` stay high and `gate_permit` is low, until UVLO returns the block to off, after which a new start-up attempt follows.
- R9: With `latch_mode` = 1, an over-voltage fault or a low `therm_ok` leads to the locked state. There `core_en` and `startup_off` are low, and start and UVLO flags are ignored. The block leaves only when `vdd_below_rel` is seen, and it then goes to off.
- R10: With `latch_mode` = 1, the general protection trip `flt_trip` still takes the drain path and restarts automatically.
- R11: `seq_state` encodes the states as off=0, thermal check=1, calibration=2, soft-start=3, run=4, drain=5, locked=6.
- R12: All seven flag inputs pass through a two-stage synchronizer. A flag driven between clock edges changes the state on the third rising edge after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_mode | input | 1 | Static selection: 1 = over-voltage/thermal faults latch |
| vdd_above_start | input | 1 | Rail above start threshold (asynchronous) |
| vdd_below_uvlo | input | 1 | Rail below UVLO threshold (asynchronous) |
| vdd_below_rel | input | 1 | Rail below latch release level (asynchronous) |
| therm_ok | input | 1 | Thermal shutdown input is above its threshold (asynchronous) |
| cal_done | input | 1 | Calibration finished handshake (asynchronous) |
| flt_ovp | input | 1 | Over-voltage fault flag (asynchronous) |
| flt_trip | input | 1 | Other protection trip: over-current, sense short, timeouts (asynchronous) |
| sw_tick | input | 1 | One-clock pulse per switching cycle from the PWM core |
| core_en | output | 1 | Core bias enable |
| startup_off | output | 1 | Turns the external start-up device off |
| gate_permit | output | 1 | Gate driver may switch |
| cal_req | output | 1 | Requests the calibration pass |
| pw_ceiling | output | 8 | Upper limit for the pulse width |
| seq_state | output | 3 | Encoded state |

## Verification
Two functions can act in the same cycle: the UVLO shutdown and the fault dispatch toward drain or locked. The bench drives `vdd_below_uvlo` and `flt_ovp` high together at one falling edge during soft-start. Both pass the synchronizer on the same edge, and the scoreboard expects a transition to off with no drain or locked state between. A second overlap sits at the top of the ramp, where the final ceiling step and the move to run come one update apart. The bench judges this by the ceiling value and the state after the 240th switching tick.

// File: rtl/psu_seq_pkg.sv
package psu_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_THERM = 3'd1,
    ST_CAL   = 3'd2,
    ST_RAMP  = 3'd3,
    ST_RUN   = 3'd4,
    ST_DRAIN = 3'd5,
    ST_LOCK  = 3'd6
  } seq_state_e;

  // positions of the flags in the synchronized bundle
  localparam int FL_START = 0;
  localparam int FL_UVLO  = 1;
  localparam int FL_REL   = 2;
  localparam int FL_THERM = 3;
  localparam int FL_CAL   = 4;
  localparam int FL_OVP   = 5;
  localparam int FL_TRIP  = 6;
  localparam int FL_COUNT = 7;

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] safe_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= raw_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign safe_out = stage_q[STAGES-1];

endmodule

// File: rtl/ramp_limit.sv
module ramp_limit #(
  parameter int CEIL_W = 8,
  parameter int DWELL  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ramp_en,
  input  logic              tick,
  output logic [CEIL_W-1:0] ceil_val,
  output logic              ceil_top
);

  localparam int                CNT_W  = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CEIL_W-1:0] C_INIT = CEIL_W'(2 ** (CEIL_W - 4));
  localparam logic [CEIL_W:0]   C_STEP = (CEIL_W + 1)'(2 ** (CEIL_W - 4));
  localparam logic [CEIL_W-1:0] C_MAX  = {CEIL_W{1'b1}};
  localparam logic [CNT_W-1:0]  C_LAST = CNT_W'(DWELL - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CEIL_W-1:0] ceil_q, ceil_d;
  logic [CEIL_W:0]   sum_w;
  logic              cnt_ce;

  assign cnt_ce = ramp_en && tick;
  assign sum_w  = {1'b0, ceil_q} + C_STEP;

  always_comb begin
    cnt_d  = cnt_q;
    ceil_d = ceil_q;
    if (!ramp_en) begin
      cnt_d  = '0;
      ceil_d = C_INIT;
    end else if (cnt_ce) begin
      if (cnt_q == C_LAST) begin
        cnt_d  = '0;
        ceil_d = sum_w[CEIL_W] ? C_MAX : sum_w[CEIL_W-1:0];
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ceil_q <= C_INIT;
    end else begin
      cnt_q  <= cnt_d;
      ceil_q <= ceil_d;
    end
  end

  assign ceil_val = ceil_q;
  assign ceil_top = (ceil_q == C_MAX);

  // R5: while ramping the ceiling never moves down
  a_r5_no_descend: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && $past(ramp_en)) |-> (ceil_q >= $past(ceil_q)));

  // R5: without a tick nothing moves inside an active ramp
  a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_en && !tick) |=> $stable(ceil_q));

endmodule

// File: rtl/boot_fsm.sv
module boot_fsm
  import psu_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       latch_mode,
  input  logic       start_s,
  input  logic       uvlo_s,
  input  logic       rel_s,
  input  logic       therm_s,
  input  logic       cal_s,
  input  logic       ovp_s,
  input  logic       trip_s,
  input  logic       ramp_top,
  output seq_state_e state
);

  seq_state_e st_q, st_d;
  logic       lock_cause;
  logic       any_fault;
  seq_state_e fault_dest;

  assign lock_cause = ovp_s || !therm_s;
  assign any_fault  = lock_cause || trip_s;
  assign fault_dest = (latch_mode && lock_cause) ? ST_LOCK : ST_DRAIN;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:   if (start_s && !uvlo_s) st_d = ST_THERM;
      ST_THERM: st_d = therm_s ? ST_CAL : (latch_mode ? ST_LOCK : ST_DRAIN);
      ST_CAL:   if (cal_s) st_d = ST_RAMP;
      ST_RAMP: begin
        if (any_fault)     st_d = fault_dest;
        else if (ramp_top) st_d = ST_RUN;
      end
      ST_RUN:   if (any_fault) st_d = fault_dest;
      ST_DRAIN: st_d = ST_DRAIN;
      ST_LOCK:  if (rel_s) st_d = ST_OFF;
      default:  st_d = ST_OFF;
    endcase
    // supply collapse overrides all else except the latch
    if (uvlo_s && (st_q != ST_LOCK)) st_d = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign state = st_q;

  // R7: UVLO wins over any concurrent event
  a_r7_uvlo_off: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo_s && (st_q != ST_LOCK)) |=> (st_q == ST_OFF));

  // R9: locked state holds until the release flag
  a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_LOCK) && !rel_s) |=> (st_q == ST_LOCK));

  // R3: calibration is entered only from the thermal check
  a_r3_cal_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_CAL) && ($past(st_q) != ST_CAL)) |-> ($past(st_q) == ST_THERM));

  // R8: drain state persists until UVLO
  a_r8_drain_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_DRAIN) && !uvlo_s) |=> (st_q == ST_DRAIN));

endmodule

// File: rtl/psu_boot_seq.sv
module psu_boot_seq
  import psu_seq_pkg::*;
#(
  parameter int CEIL_W      = 8,
  parameter int RAMP_DWELL  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_mode,
  input  logic              vdd_above_start,
  input  logic              vdd_below_uvlo,
  input  logic              vdd_below_rel,
  input  logic              therm_ok,
  input  logic              cal_done,
  input  logic              flt_ovp,
  input  logic              flt_trip,
  input  logic              sw_tick,
  output logic              core_en,
  output logic              startup_off,
  output logic              gate_permit,
  output logic              cal_req,
  output logic [CEIL_W-1:0] pw_ceiling,
  output logic [2:0]        seq_state
);

  logic [FL_COUNT-1:0] raw_flags, safe_flags;
  logic [CEIL_W-1:0]   ramp_val;
  logic                ramp_top;
  logic                ramp_en;
  seq_state_e          state;

  always_comb begin
    raw_flags           = '0;
    raw_flags[FL_START] = vdd_above_start;
    raw_flags[FL_UVLO]  = vdd_below_uvlo;
    raw_flags[FL_REL]   = vdd_below_rel;
    raw_flags[FL_THERM] = therm_ok;
    raw_flags[FL_CAL]   = cal_done;
    raw_flags[FL_OVP]   = flt_ovp;
    raw_flags[FL_TRIP]  = flt_trip;
  end

  flag_sync #(
    .WIDTH  (FL_COUNT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (raw_flags),
    .safe_out (safe_flags)
  );

  boot_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_mode (latch_mode),
    .start_s    (safe_flags[FL_START]),
    .uvlo_s     (safe_flags[FL_UVLO]),
    .rel_s      (safe_flags[FL_REL]),
    .therm_s    (safe_flags[FL_THERM]),
    .cal_s      (safe_flags[FL_CAL]),
    .ovp_s      (safe_flags[FL_OVP]),
    .trip_s     (safe_flags[FL_TRIP]),
    .ramp_top   (ramp_top),
    .state      (state)
  );

  assign ramp_en = (state == ST_RAMP);

  ramp_limit #(
    .CEIL_W (CEIL_W),
    .DWELL  (RAMP_DWELL)
  ) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ramp_en  (ramp_en),
    .tick     (sw_tick),
    .ceil_val (ramp_val),
    .ceil_top (ramp_top)
  );

  always_comb begin
    core_en     = (state != ST_OFF) && (state != ST_LOCK);
    startup_off = core_en;
    gate_permit = (state == ST_RAMP) || (state == ST_RUN);
    cal_req     = (state == ST_CAL);
    unique case (state)
      ST_RAMP: pw_ceiling = ramp_val;
      ST_RUN:  pw_ceiling = {CEIL_W{1'b1}};
      default: pw_ceiling = '0;
    endcase
    seq_state = state;
  end

  // R6: a switching permit always comes with a nonzero width limit
  a_r6_gate_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    gate_permit |-> (pw_ceiling != '0));

  // R4: gate never permitted while calibration is requested
  a_r4_cal_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req |-> !gate_permit);

endmodule

// File: tb/test_psu_boot_seq.sv
module test_psu_boot_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       latch_mode, vdd_above_start, vdd_below_uvlo, vdd_below_rel;
  logic       therm_ok, cal_done, flt_ovp, flt_trip, sw_tick;
  logic       core_en, startup_off, gate_permit, cal_req;
  logic [7:0] pw_ceiling;
  logic [2:0] seq_state;

  int checks   = 0;
  int failures = 0;
  int exp_q[$];
  logic [2:0] last_seen;
  logic       mon_on = 1'b0;

  always #5 clk = ~clk;

  psu_boot_seq i_psu_boot_seq (
    .clk(clk), .rst_n(rst_n), .latch_mode(latch_mode),
    .vdd_above_start(vdd_above_start), .vdd_below_uvlo(vdd_below_uvlo),
    .vdd_below_rel(vdd_below_rel), .therm_ok(therm_ok), .cal_done(cal_done),
    .flt_ovp(flt_ovp), .flt_trip(flt_trip), .sw_tick(sw_tick),
    .core_en(core_en), .startup_off(startup_off), .gate_permit(gate_permit),
    .cal_req(cal_req), .pw_ceiling(pw_ceiling), .seq_state(seq_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_state(input int code);
    exp_q.push_back(code);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_pulse();
    sw_tick = 1'b1;
    @(negedge clk);
    sw_tick = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor: every state change must match the queue head (R11 codes)
  always @(negedge clk) begin
    if (mon_on && (seq_state != last_seen)) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R11 unexpected state actual=%0d expected=none", seq_state);
      end else begin
        chk("R11 state sequence", int'(seq_state), exp_q.pop_front());
      end
      last_seen = seq_state;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    latch_mode = 1'b0; vdd_above_start = 1'b0; vdd_below_uvlo = 1'b0;
    vdd_below_rel = 1'b0; therm_ok = 1'b1; cal_done = 1'b0;
    flt_ovp = 1'b0; flt_trip = 1'b0; sw_tick = 1'b0;
    last_seen = 3'd0;
    wait_clk(3);
    chk("R1 state in reset", seq_state, 0);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R1 state", seq_state, 0);
    chk("R1 core_en", core_en, 0);
    chk("R1 startup_off", startup_off, 0);
    chk("R1 gate_permit", gate_permit, 0);
    chk("R1 cal_req", cal_req, 0);
    chk("R1 pw_ceiling", pw_ceiling, 0);
    mon_on = 1'b1;

    // start-up with exact synchronizer latency
    expect_state(1); expect_state(2);
    vdd_above_start = 1'b1;
    wait_clk(2);
    chk("R12 no change after two edges", seq_state, 0);
    wait_clk(1);
    chk("R12 thermal check on third edge", seq_state, 1);
    chk("R2 core_en when enabled", core_en, 1);
    chk("R2 startup_off when enabled", startup_off, 1);
    wait_clk(1);
    chk("R3 calibration follows thermal check", seq_state, 2);
    chk("R4 cal_req in calibration", cal_req, 1);
    chk("R4 gate off in calibration", gate_permit, 0);
    wait_clk(10);
    chk("R4 calibration waits for done", seq_state, 2);

    expect_state(3);
    cal_done = 1'b1;
    wait_clk(6);
    chk("R3 soft-start after calibration", seq_state, 3);
    chk("R4 cal_req dropped", cal_req, 0);
    chk("R5 initial ceiling", pw_ceiling, 16);
    chk("R6 gate in soft-start", gate_permit, 1);

    for (int i = 1; i <= 15; i++) tick_pulse();
    chk("R5 ceiling after 15 ticks", pw_ceiling, 16);
    tick_pulse();
    chk("R5 ceiling after 16 ticks", pw_ceiling, 32);
    for (int i = 17; i <= 239; i++) tick_pulse();
    chk("R5 ceiling after 239 ticks", pw_ceiling, 240);
    chk("R5 still soft-start", seq_state, 3);
    expect_state(4);
    tick_pulse();
    chk("R5 run after saturation", seq_state, 4);
    chk("R5 ceiling saturated", pw_ceiling, 255);
    chk("R6 gate in run", gate_permit, 1);

    // non-latching fault in auto mode
    expect_state(5);
    flt_trip = 1'b1;
    wait_clk(6);
    chk("R8 drain state", seq_state, 5);
    chk("R8 core stays biased", core_en, 1);
    chk("R8 gate off in drain", gate_permit, 0);
    flt_trip = 1'b0;
    wait_clk(6);
    chk("R8 drain holds until UVLO", seq_state, 5);
    expect_state(0);
    vdd_below_uvlo = 1'b1; vdd_above_start = 1'b0;
    wait_clk(6);
    chk("R7 off after UVLO", seq_state, 0);
    chk("R7 core_en off", core_en, 0);

    // retry, calibration passes straight through with done held high
    expect_state(1); expect_state(2); expect_state(3);
    vdd_below_uvlo = 1'b0; vdd_above_start = 1'b1;
    wait_clk(8);
    chk("R8 retry reaches soft-start", seq_state, 3);
    chk("R5 ceiling restarts", pw_ceiling, 16);

    // same-cycle UVLO and over-voltage: UVLO wins
    expect_state(0);
    vdd_below_uvlo = 1'b1; flt_ovp = 1'b1;
    wait_clk(6);
    chk("R7 UVLO beats fault", seq_state, 0);

    // thermal check failure, auto mode
    flt_ovp = 1'b0; therm_ok = 1'b0;
    wait_clk(4);
    expect_state(1); expect_state(5);
    vdd_below_uvlo = 1'b0;
    wait_clk(8);
    chk("R3 failed thermal check drains", seq_state, 5);
    chk("R3 calibration never requested", cal_req, 0);
    expect_state(0);
    vdd_below_uvlo = 1'b1;
    wait_clk(6);
    therm_ok = 1'b1;

    // latching variant
    latch_mode = 1'b1;
    expect_state(1); expect_state(2); expect_state(3);
    vdd_below_uvlo = 1'b0;
    wait_clk(8);
    chk("R9 latch run-up to soft-start", seq_state, 3);
    expect_state(6);
    flt_ovp = 1'b1;
    wait_clk(6);
    chk("R9 locked on over-voltage", seq_state, 6);
    chk("R9 core_en low when locked", core_en, 0);
    chk("R9 startup_off low when locked", startup_off, 0);
    flt_ovp = 1'b0;
    vdd_below_uvlo = 1'b1; vdd_above_start = 1'b0;
    wait_clk(6);
    vdd_below_uvlo = 1'b0; vdd_above_start = 1'b1;
    wait_clk(6);
    chk("R9 UVLO and start ignored when locked", seq_state, 6);
    chk("R9 gate off when locked", gate_permit, 0);
    expect_state(0);
    vdd_below_uvlo = 1'b1; vdd_above_start = 1'b0; vdd_below_rel = 1'b1;
    wait_clk(6);
    chk("R9 release clears lock", seq_state, 0);

    expect_state(1); expect_state(2); expect_state(3);
    vdd_below_rel = 1'b0; vdd_below_uvlo = 1'b0; vdd_above_start = 1'b1;
    wait_clk(8);
    expect_state(5);
    flt_trip = 1'b1;
    wait_clk(6);
    chk("R10 trip drains in latch mode", seq_state, 5);
    flt_trip = 1'b0;
    expect_state(0);
    vdd_below_uvlo = 1'b1;
    wait_clk(6);
    chk("R10 auto restart path reaches off", seq_state, 0);

    chk("R11 scoreboard drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule